// File: doc/BRIEF.md
# External Interrupt Request Controller

This block gathers external interrupt requests for a single processor core. Any agent on the system bus can post a request by writing a request number to one 32-bit word. The block turns that number into one pending bit. A periodic timer alarm posts request number 0 through a dedicated pulse input.

The processor side has two write ports. One is a pending port: every 1 in the written value retires the matching pending bit. The other is a mask port that replaces the enable mask as a whole. Both registers are also visible to the core as outputs.

The block drives a level request whenever an unmasked pending bit exists. It also drives a qualified "take" signal, which is the request gated by the core's global interrupt-enable bit.

Top module: `ext_irq_ctrl`

## Requirements
- R1: A bus write with all four byte enables set (`bus_be` = 4'b1111) sets exactly one pending bit. The bit index is 31 minus the low 5 bits of `bus_wdata`, so value 0 sets bit 31 and value 31 sets bit 0. Data bits above bit 4 are ignored. Other pending bits keep their value.
- R2: A processor pending write (`cpu_pend_clr` high) clears every pending bit whose bit in `cpu_wdata` is 1 and leaves every other bit unchanged.
- R3: A full-word bus read returns, on `bus_rdata` in the cycle after the access with `bus_ack` high, the pending register as it stood at the access edge.
- R4: A bus access whose byte enables are not 4'b1111 changes no state. Its response in the next cycle has `bus_ack` and `bus_err` high and `bus_rdata` equal to 0.
- R5: A processor mask write (`cpu_mask_wr` high) loads `cpu_wdata` into the mask register in full.
- R6: `irq_req` is high exactly when the current pending register AND the current mask register is nonzero. It follows every register update without extra delay.
- R7: `irq_take` is high exactly when `irq_req` and `core_ie` are both high.
- R8: A pulse on `alarm` sets pending bit 31, which is request number 0. It can coincide with a bus write, and then both bits are set.
- R9: When a set (from the bus or from the alarm) and a processor clear hit the same bit in the same cycle, the bit ends up set.
- R10: While reset is asserted, and until the first edge after reset is released, the pending and mask registers read zero and `bus_ack`, `bus_err`, `irq_req` and `irq_take` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Bus access strobe for the request word |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_be | input | 4 | Byte enables; only 4'b1111 is accepted |
| bus_wdata | input | 32 | Bus write data (request number in bits 4:0) |
| bus_ack | output | 1 | Response strobe, one cycle after the access |
| bus_err | output | 1 | Response error flag for a rejected access size |
| bus_rdata | output | 32 | Response read data |
| cpu_pend_clr | input | 1 | Processor write-one-to-clear strobe for pending |
| cpu_mask_wr | input | 1 | Processor mask load strobe |
| cpu_wdata | input | 32 | Processor write data for both ports |
| alarm | input | 1 | Timer alarm pulse, posts request number 0 |
| core_ie | input | 1 | Core global interrupt-enable bit |
| pending | output | 32 | Current pending register |
| mask | output | 32 | Current mask register |
| irq_req | output | 1 | Level request: pending AND mask nonzero |
| irq_take | output | 1 | Request qualified by core_ie |

## Verification
The hardest case to reach from the ports is a set and a clear landing on the same bit in the same cycle. In the worst version, a bus post and an alarm both set bits at the edge where the processor clears all of them. The stimulus drives these together: a bus write with request number 0 plus the alarm, against a clear of all ones. It then repeats the collision with other request numbers. A long pseudo-random phase overlaps posts, clears, mask loads, rejected accesses and reads. A behavioural model in the bench is compared against every output after every clock.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int unsigned EIRQ_W    = 32;
  localparam int unsigned EIRQ_BE_W = EIRQ_W / 8;
  localparam int unsigned EIRQ_IDX_W = $clog2(EIRQ_W);

  typedef struct packed {
    logic ack;
    logic err;
  } eirq_rsp_t;
endpackage

// File: rtl/eirq_post_decode.sv
module eirq_post_decode #(
  parameter int unsigned W    = 32,
  parameter int unsigned BE_W = W / 8
) (
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [BE_W-1:0] bus_be,
  input  logic [W-1:0]    bus_wdata,
  input  logic            alarm,
  output logic            access_ok,
  output logic [W-1:0]    set_vec
);
  localparam int unsigned IDX_W = $clog2(W);

  logic             post_hit;
  logic [IDX_W-1:0] req_num;

  always_comb begin
    access_ok = &bus_be;
    post_hit  = bus_valid && bus_write && access_ok;
    req_num   = bus_wdata[IDX_W-1:0];
  end

  // Big-endian numbering: request n lands on bit W-1-n; alarm is request 0.
  for (genvar gi = 0; gi < W; gi++) begin : g_set
    localparam logic [IDX_W-1:0] MY_NUM = IDX_W'(W - 1 - gi);
    if (gi == W - 1) begin : g_top
      assign set_vec[gi] = (post_hit && (req_num == MY_NUM)) || alarm;
    end else begin : g_rest
      assign set_vec[gi] = post_hit && (req_num == MY_NUM);
    end
  end
endmodule

// File: rtl/eirq_pending_reg.sv
module eirq_pending_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_en,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] pend_q
);
  logic [W-1:0] clr_eff;
  logic [W-1:0] pend_d;
  logic         pend_ce;

  always_comb begin
    clr_eff = clr_en ? clr_vec : '0;
    pend_ce = clr_en || (|set_vec);
    // set is applied after clear so a colliding set wins
    pend_d  = (pend_q & ~clr_eff) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_ce) begin
      pend_q <= pend_d;
    end
  end

  assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0));

  assert_set_sticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

  assert_untouched_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((pend_q & ~$past(set_vec)) == ($past(pend_q) & ~$past(set_vec))));
endmodule

// File: rtl/eirq_mask_reg.sv
module eirq_mask_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q
);
  logic [W-1:0] mask_d;

  always_comb begin
    mask_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_en) begin
      mask_q <= mask_d;
    end
  end

  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mask_q == $past(wdata)));

  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/eirq_bus_resp.sv
module eirq_bus_resp
  import eirq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_valid,
  input  logic         bus_write,
  input  logic         access_ok,
  input  logic [W-1:0] pend_q,
  output eirq_rsp_t    rsp_q,
  output logic [W-1:0] rdata_q
);
  eirq_rsp_t    rsp_d;
  logic [W-1:0] rdata_d;

  always_comb begin
    rsp_d.ack = bus_valid;
    rsp_d.err = bus_valid && !access_ok;
    rdata_d   = (bus_valid && !bus_write && access_ok) ? pend_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q   <= '0;
      rdata_q <= '0;
    end else begin
      rsp_q   <= rsp_d;
      rdata_q <= rdata_d;
    end
  end

  assert_bad_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !access_ok) |=> (rsp_q.ack && rsp_q.err && (rdata_q == '0)));

  assert_read_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && access_ok) |=> (rsp_q.ack && !rsp_q.err && (rdata_q == $past(pend_q))));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [EIRQ_BE_W-1:0] bus_be,
  input  logic [EIRQ_W-1:0]    bus_wdata,
  output logic                 bus_ack,
  output logic                 bus_err,
  output logic [EIRQ_W-1:0]    bus_rdata,
  input  logic                 cpu_pend_clr,
  input  logic                 cpu_mask_wr,
  input  logic [EIRQ_W-1:0]    cpu_wdata,
  input  logic                 alarm,
  input  logic                 core_ie,
  output logic [EIRQ_W-1:0]    pending,
  output logic [EIRQ_W-1:0]    mask,
  output logic                 irq_req,
  output logic                 irq_take
);
  localparam int unsigned W = EIRQ_W;

  logic         rst_meta_q;
  logic         rst_sync_n;
  logic         access_ok;
  logic [W-1:0] set_vec;
  logic [W-1:0] pend_q;
  logic [W-1:0] mask_q;
  eirq_rsp_t    rsp_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  eirq_post_decode #(.W(W), .BE_W(EIRQ_BE_W)) u_decode (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .alarm     (alarm),
    .access_ok (access_ok),
    .set_vec   (set_vec)
  );

  eirq_pending_reg #(.W(W)) u_pend (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_vec (set_vec),
    .clr_en  (cpu_pend_clr),
    .clr_vec (cpu_wdata),
    .pend_q  (pend_q)
  );

  eirq_mask_reg #(.W(W)) u_mask (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (cpu_mask_wr),
    .wdata  (cpu_wdata),
    .mask_q (mask_q)
  );

  eirq_bus_resp #(.W(W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .access_ok (access_ok),
    .pend_q    (pend_q),
    .rsp_q     (rsp_q),
    .rdata_q   (bus_rdata)
  );

  always_comb begin
    pending  = pend_q;
    mask     = mask_q;
    bus_ack  = rsp_q.ack;
    bus_err  = rsp_q.err;
    irq_req  = |(pend_q & mask_q);
    irq_take = irq_req && core_ie;
  end

  assert_alarm_post_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    alarm |=> pending[W-1]);

  assert_take_gated_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !core_ie |-> !irq_take);

  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_sync_n |-> ((pending == '0) && (mask == '0) && !bus_ack && !irq_req));
endmodule

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic        bus_ack, bus_err;
  logic [31:0] bus_rdata;
  logic        cpu_pend_clr, cpu_mask_wr;
  logic [31:0] cpu_wdata;
  logic        alarm, core_ie;
  logic [31:0] pending, mask;
  logic        irq_req, irq_take;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // behavioural model state
  logic [31:0] m_pend, m_mask, m_rdata;
  logic        m_ack, m_err;
  int unsigned lfsr = 32'hACE1_2024;

  always #4 clk = ~clk;

  ext_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err),
    .bus_rdata(bus_rdata), .cpu_pend_clr(cpu_pend_clr),
    .cpu_mask_wr(cpu_mask_wr), .cpu_wdata(cpu_wdata), .alarm(alarm),
    .core_ie(core_ie), .pending(pending), .mask(mask),
    .irq_req(irq_req), .irq_take(irq_take)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    logic rq;
    rq = |(m_pend & m_mask);
    chk("R2 pending", pending, m_pend);
    chk("R5 mask", mask, m_mask);
    chk("R6 irq_req", 32'(irq_req), 32'(rq));
    chk("R7 irq_take", 32'(irq_take), 32'(rq & core_ie));
    chk("R3 bus_ack", 32'(bus_ack), 32'(m_ack));
    chk("R4 bus_err", 32'(bus_err), 32'(m_err));
    chk("R3 bus_rdata", bus_rdata, m_rdata);
  endtask

  task automatic idle_inputs();
    bus_valid = 0; bus_write = 0; bus_be = 4'hF; bus_wdata = '0;
    cpu_pend_clr = 0; cpu_mask_wr = 0; cpu_wdata = '0; alarm = 0;
  endtask

  // inputs already driven after a negedge; model the edge, then compare
  task automatic step();
    logic [31:0] setv;
    logic        full;
    full = (bus_be == 4'hF);
    m_ack = bus_valid;
    m_err = bus_valid && !full;
    m_rdata = (bus_valid && !bus_write && full) ? m_pend : 32'h0;
    setv = 32'h0;
    if (bus_valid && bus_write && full) setv = setv | (32'h1 << (31 - (bus_wdata & 31)));
    if (alarm) setv = setv | 32'h8000_0000;
    if (cpu_pend_clr) m_pend = m_pend & ~cpu_wdata;
    m_pend = m_pend | setv;
    if (cpu_mask_wr) m_mask = cpu_wdata;
    @(posedge clk);
    @(negedge clk);
    compare_all();
    idle_inputs();
  endtask

  task automatic bus_post(input logic [31:0] v);
    bus_valid = 1; bus_write = 1; bus_wdata = v; step();
  endtask

  task automatic bus_read();
    bus_valid = 1; bus_write = 0; step();
  endtask

  function automatic logic [31:0] rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    core_ie = 0;
    rst_n = 0;
    m_pend = 0; m_mask = 0; m_ack = 0; m_err = 0; m_rdata = 0;
    repeat (3) @(negedge clk);
    // R10: quiet state during reset
    compare_all();
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    compare_all();

    // R5: mask load, R6 no request with empty pending
    cpu_mask_wr = 1; cpu_wdata = 32'hFFFF_FFFF; step();
    // R1: every request number maps to bit 31-N; upper data bits ignored
    for (int n = 0; n < 32; n++) begin
      bus_post(32'hABCD_0000 | 32'(n) | (32'(n) << 5));
      chk("R1 bit placement", pending & (32'h1 << (31 - n)), 32'h1 << (31 - n));
    end
    bus_read();   // R3
    // R2: partial clear
    cpu_pend_clr = 1; cpu_wdata = 32'h0F0F_00FF; step();
    bus_read();
    cpu_pend_clr = 1; cpu_wdata = 32'hFFFF_FFFF; step();
    chk("R2 all cleared", pending, 32'h0);
    // R4: narrow accesses ignored with error
    bus_valid = 1; bus_write = 1; bus_be = 4'b0011; bus_wdata = 32'd5; step();
    chk("R4 no set", pending, 32'h0);
    bus_valid = 1; bus_write = 0; bus_be = 4'b1110; step();
    step();
    // R8: alarm posts bit 31
    alarm = 1; step();
    chk("R8 alarm bit", pending, 32'h8000_0000);
    // R7: take gated by core_ie
    core_ie = 1; step();
    chk("R7 take", 32'(irq_take), 32'h1);
    // R6: mask off the only pending bit
    cpu_mask_wr = 1; cpu_wdata = 32'h7FFF_FFFF; step();
    chk("R6 masked", 32'(irq_req), 32'h0);
    // R9: collision, bus post + alarm vs clear-all
    bus_valid = 1; bus_write = 1; bus_wdata = 32'd0; alarm = 1;
    cpu_pend_clr = 1; cpu_wdata = 32'hFFFF_FFFF; step();
    chk("R9 set wins", pending, 32'h8000_0000);
    for (int n = 1; n < 32; n += 7) begin
      bus_valid = 1; bus_write = 1; bus_wdata = 32'(n);
      cpu_pend_clr = 1; cpu_wdata = 32'h1 << (31 - n); step();
    end
    // R8 with a simultaneous bus post
    alarm = 1; bus_valid = 1; bus_write = 1; bus_wdata = 32'd31; step();

    // mixed pseudo-random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = rnd();
      bus_valid    = r[0] | r[1];
      bus_write    = r[2] | r[3];
      bus_be       = (r[4:3] == 2'b00) ? r[11:8] : 4'hF;
      bus_wdata    = rnd();
      cpu_pend_clr = (r[14:12] == 3'b000);
      cpu_mask_wr  = (r[17:15] == 3'b000);
      cpu_wdata    = rnd() & rnd();
      alarm        = (r[21:19] == 3'b000);
      core_ie      = r[24];
      step();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule